// File: doc/BRIEF.md
# HDLC Receive Address Recognition Filter

This block sits behind an HDLC receive deframer and decides, frame by frame, whether a received frame is addressed to this station. The deframer presents each frame as a byte stream. A start-of-frame strobe comes in a cycle of its own. Data bytes follow, each marked by a byte-valid strobe. An end-of-frame strobe, also in a cycle of its own, closes the frame. The filter compares the leading address byte, or the leading two bytes, against two programmable individual values and a set of fixed group values. It issues one accept/reject decision per filtered frame, together with a code that says which value matched. It forwards the payload of accepted frames and silently drops the rest of rejected frames.

A 3-bit mode input selects the behaviour. Mode 010 compares one address byte. Mode 011 compares two address bytes. Every other mode passes frames through untouched. The mode and the four address values are captured at start-of-frame, so software may rewrite them at any time without disturbing the frame in progress.

Address byte layout: in the high (first) byte, bits 7:2 are the address, bit 1 is the command/response flag and bit 0 is the extension flag. In the low (second) byte, bits 7:1 are the address and bit 0 is the extension flag.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, dec_vld, out_vld and out_eof are 0, and they stay 0 until a frame is presented.
- R2: In mode 011 (two-byte), dec_vld pulses one clock after the second address byte. dec_accept is 1 only when both bytes match. The high byte matches when bits 7:2 equal individual value 1 or 2, or equal all ones (fixed groups 0xFE/0xFC). The low byte matches when bits 7:1 equal individual value 1 or 2, or equal all ones (fixed group 0xFF).
- R3: Bit 1 (command/response) of the high byte is ignored in both the received byte and the stored individual values.
- R4: Bit 0 (extension) of the final compared address byte must be 1, otherwise the frame is rejected.
- R5: In mode 010 (one-byte), only the first byte is compared, dec_vld pulses one clock after it, and the second byte is forwarded as payload.
- R6: hi_code and lo_code, valid with dec_vld, give 01 for individual value 1, 10 for individual value 2, 11 for a group match and 00 for no match. Individual 1 wins over individual 2, and individual 2 wins over group. lo_code is 00 in one-byte mode.
- R7: After an accept, each later byte appears on out_data with out_vld one clock after its input, and out_eof follows the frame's end one clock later. After a reject, neither out_vld nor out_eof is raised until the next start-of-frame.
- R8: A frame that ends before all compared address bytes have arrived produces dec_vld with dec_accept = 0 one clock after the end strobe. hi_code is 00 if no byte had arrived, and lo_code is 00.
- R9: In any mode whose upper two bits are not 01, every byte and the end strobe are forwarded one clock later, and no decision is issued.
- R10: Mode and address inputs are sampled on the start-of-frame cycle. Changes during the frame do not affect it.
- R11: In the filtering modes the compared address bytes themselves are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame strobe (own cycle) |
| byte_vld | input | 1 | Received byte valid |
| byte_in | input | 8 | Received byte |
| eof | input | 1 | End-of-frame strobe (own cycle) |
| cfg_mode | input | 3 | Mode select |
| cfg_hi1 | input | 8 | High-byte individual value 1 |
| cfg_hi2 | input | 8 | High-byte individual value 2 |
| cfg_lo1 | input | 8 | Low-byte individual value 1 |
| cfg_lo2 | input | 8 | Low-byte individual value 2 |
| out_vld | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_eof | output | 1 | Forwarded end-of-frame |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| hi_code | output | 2 | High-byte match code |
| lo_code | output | 2 | Low-byte match code |

## Verification
Two functions can coincide in one cycle. The first is start-of-frame and a rewrite of the configuration inputs. The second is the end strobe and the decision on the last address byte: the end strobe arrives in the very cycle the decision is being registered. The bench drives new configuration together with each start strobe, and in one frame scrambles it immediately afterwards. It also closes frames right after the address bytes and before them. A scoreboard queue holds the expected decision, code, payload and end events in order. Every output event is judged against the next queued item, and any output that was not predicted is counted as a failure.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int AW = 8;
  localparam int MW = 3;
  localparam logic [AW-1:0] HI_MASK = 8'hFC;
  localparam logic [AW-1:0] LO_MASK = 8'hFE;
  localparam logic [AW-1:0] HI_GRP_A = 8'hFE;
  localparam logic [AW-1:0] HI_GRP_B = 8'hFC;
  localparam logic [AW-1:0] LO_GRP = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_ADDR1, S_ADDR2, S_PASS, S_DROP} fstate_t;
  typedef enum logic [1:0] {MC_NONE = 2'b00, MC_IND1 = 2'b01,
                            MC_IND2 = 2'b10, MC_GRP = 2'b11} mcode_t;

  function automatic logic is_filter(input logic [MW-1:0] m);
    return m[MW-1:1] == 2'b01;
  endfunction

  function automatic mcode_t classify(input logic [AW-1:0] rx, ind1, ind2,
                                      mask, ga, gb);
    logic [AW-1:0] r;
    r = rx & mask;
    if (r == (ind1 & mask)) return MC_IND1;
    if (r == (ind2 & mask)) return MC_IND2;
    if (r == (ga & mask) || r == (gb & mask)) return MC_GRP;
    return MC_NONE;
  endfunction
endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match
  import hdlc_af_pkg::*;
#(
  parameter logic [AW-1:0] CMP_MASK = 8'hFF,
  parameter logic [AW-1:0] GRP_A    = 8'hFF,
  parameter logic [AW-1:0] GRP_B    = 8'hFF
) (
  input  logic [AW-1:0] rx,
  input  logic [AW-1:0] ind1,
  input  logic [AW-1:0] ind2,
  output mcode_t        code,
  output logic          hit
);
  assign code = classify(rx, ind1, ind2, CMP_MASK, GRP_A, GRP_B);
  assign hit  = (code != MC_NONE);
endmodule

// File: rtl/hdlc_af_cfg.sv
module hdlc_af_cfg
  import hdlc_af_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [MW-1:0]            mode_in,
  input  logic [NREG-1:0][AW-1:0]  addr_in,
  output logic [MW-1:0]            mode_q,
  output logic [NREG-1:0][AW-1:0]  addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= '0;
    else if (load) mode_q <= mode_in;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q[i] <= '0;
      else if (load) addr_q[i] <= addr_in[i];
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          eof,
  input  logic [2:0]    cfg_mode,
  input  logic [7:0]    cfg_hi1,
  input  logic [7:0]    cfg_hi2,
  input  logic [7:0]    cfg_lo1,
  input  logic [7:0]    cfg_lo2,
  output logic          out_vld,
  output logic [7:0]    out_data,
  output logic          out_eof,
  output logic          dec_vld,
  output logic          dec_accept,
  output logic [1:0]    hi_code,
  output logic [1:0]    lo_code
);
  localparam int NREG = 4;

  logic [MW-1:0]           mode_q;
  logic [NREG-1:0][AW-1:0] addr_q;
  mcode_t  hi_now, lo_now, hcode_q, hc_n, lc_n;
  logic    hi_hit, lo_hit;
  fstate_t st, nxt;
  logic    fwd, fwd_eof, dec_now, acc_now;

  hdlc_af_cfg #(.NREG(NREG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(sof), .mode_in(cfg_mode),
    .addr_in({cfg_lo2, cfg_lo1, cfg_hi2, cfg_hi1}),
    .mode_q(mode_q), .addr_q(addr_q)
  );

  hdlc_af_match #(.CMP_MASK(HI_MASK), .GRP_A(HI_GRP_A), .GRP_B(HI_GRP_B)) u_hi (
    .rx(byte_in), .ind1(addr_q[0]), .ind2(addr_q[1]), .code(hi_now), .hit(hi_hit)
  );

  hdlc_af_match #(.CMP_MASK(LO_MASK), .GRP_A(LO_GRP), .GRP_B(LO_GRP)) u_lo (
    .rx(byte_in), .ind1(addr_q[2]), .ind2(addr_q[3]), .code(lo_now), .hit(lo_hit)
  );

  always_comb begin
    nxt     = st;
    fwd     = 1'b0;
    fwd_eof = 1'b0;
    dec_now = 1'b0;
    acc_now = 1'b0;
    hc_n    = MC_NONE;
    lc_n    = MC_NONE;
    if (sof) begin
      nxt = is_filter(cfg_mode) ? S_ADDR1 : S_PASS;
    end else begin
      case (st)
        S_ADDR1: begin
          if (eof) begin
            dec_now = 1'b1;
            nxt     = S_IDLE;
          end else if (byte_vld) begin
            if (!mode_q[0]) begin
              dec_now = 1'b1;
              hc_n    = hi_now;
              acc_now = hi_hit && byte_in[0];
              nxt     = acc_now ? S_PASS : S_DROP;
            end else begin
              nxt = S_ADDR2;
            end
          end
        end
        S_ADDR2: begin
          hc_n = hcode_q;
          if (eof) begin
            dec_now = 1'b1;
            nxt     = S_IDLE;
          end else if (byte_vld) begin
            dec_now = 1'b1;
            lc_n    = lo_now;
            acc_now = (hcode_q != MC_NONE) && lo_hit && byte_in[0];
            nxt     = acc_now ? S_PASS : S_DROP;
          end
        end
        S_PASS: begin
          fwd     = byte_vld && !eof;
          fwd_eof = eof;
          if (eof) nxt = S_IDLE;
        end
        S_DROP:  if (eof) nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      hcode_q    <= MC_NONE;
      out_vld    <= 1'b0;
      out_data   <= '0;
      out_eof    <= 1'b0;
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      hi_code    <= 2'b00;
      lo_code    <= 2'b00;
    end else begin
      st         <= nxt;
      if (st == S_ADDR1 && byte_vld) hcode_q <= hi_now;
      out_vld    <= fwd;
      out_data   <= fwd ? byte_in : out_data;
      out_eof    <= fwd_eof;
      dec_vld    <= dec_now;
      dec_accept <= acc_now;
      hi_code    <= hc_n;
      lo_code    <= lc_n;
    end
  end

  // R7
  reject_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !dec_accept) |=> (!out_vld && !out_eof));

  // R4
  ext_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_accept) |-> $past(byte_vld && byte_in[0]));

  // R6
  accept_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_accept) |-> (hi_code != 2'b00));

  // R9
  filter_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> is_filter(mode_q));

  // R8
  early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && $past(eof)) |-> (!dec_accept && lo_code == 2'b00));

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_vld, out_vld, out_eof}));
endmodule

// File: tb/hdlc_addr_filter_tb.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, byte_vld = 0, eof = 0;
  logic [7:0] byte_in = 0;
  logic [2:0] cfg_mode = 0;
  logic [7:0] cfg_hi1 = 0, cfg_hi2 = 0, cfg_lo1 = 0, cfg_lo2 = 0;
  logic out_vld, out_eof, dec_vld, dec_accept;
  logic [7:0] out_data;
  logic [1:0] hi_code, lo_code;

  always #4 clk = ~clk;

  hdlc_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_in(byte_in),
    .eof(eof), .cfg_mode(cfg_mode), .cfg_hi1(cfg_hi1), .cfg_hi2(cfg_hi2),
    .cfg_lo1(cfg_lo1), .cfg_lo2(cfg_lo2), .out_vld(out_vld), .out_data(out_data),
    .out_eof(out_eof), .dec_vld(dec_vld), .dec_accept(dec_accept),
    .hi_code(hi_code), .lo_code(lo_code)
  );

  // kind: 0 decision, 1 data, 2 end
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] data;
    logic       acc;
    logic [1:0] hc;
    logic [1:0] lc;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    errors = 0, checks = 0;
  bit    done = 0;
  bit    scramble = 0;

  function automatic logic [1:0] hi_cls(logic [7:0] b, logic [7:0] r1, logic [7:0] r2);
    if (b[7:2] == r1[7:2]) return 2'b01;
    if (b[7:2] == r2[7:2]) return 2'b10;
    if (b[7:2] == 6'h3F)   return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [1:0] lo_cls(logic [7:0] b, logic [7:0] r1, logic [7:0] r2);
    if (b[7:1] == r1[7:1]) return 2'b01;
    if (b[7:1] == r2[7:1]) return 2'b10;
    if (b[7:1] == 7'h7F)   return 2'b11;
    return 2'b00;
  endfunction

  function automatic exp_t mk(logic [1:0] k, logic [7:0] d, logic a, logic [1:0] h, logic [1:0] l);
    exp_t e;
    e.kind = k; e.data = d; e.acc = a; e.hc = h; e.lc = l;
    return e;
  endfunction

  task automatic push(exp_t e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic check(bit ok, string t, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, expv);
    end
  endtask

  task automatic send_frame(string t, logic [2:0] m, logic [7:0] h1, logic [7:0] h2,
                            logic [7:0] l1, logic [7:0] l2, logic [7:0] bytes[$]);
    int n;
    logic [1:0] hc, lc;
    logic acc;
    if (m[2:1] == 2'b01) begin
      n = m[0] ? 2 : 1;
      if (bytes.size() < n) begin
        hc = (bytes.size() == 1) ? hi_cls(bytes[0], h1, h2) : 2'b00;
        push(mk(2'd0, 8'h00, 1'b0, hc, 2'b00), t);
      end else begin
        hc  = hi_cls(bytes[0], h1, h2);
        lc  = (n == 2) ? lo_cls(bytes[1], l1, l2) : 2'b00;
        acc = (n == 1) ? (hc != 0 && bytes[0][0]) : (hc != 0 && lc != 0 && bytes[1][0]);
        push(mk(2'd0, 8'h00, acc, hc, lc), t);
        if (acc) begin
          for (int i = n; i < bytes.size(); i++) push(mk(2'd1, bytes[i], 1'b0, 2'b00, 2'b00), t);
          push(mk(2'd2, 8'h00, 1'b0, 2'b00, 2'b00), t);
        end
      end
    end else begin
      foreach (bytes[i]) push(mk(2'd1, bytes[i], 1'b0, 2'b00, 2'b00), t);
      push(mk(2'd2, 8'h00, 1'b0, 2'b00, 2'b00), t);
    end
    @(negedge clk);
    cfg_mode = m; cfg_hi1 = h1; cfg_hi2 = h2; cfg_lo1 = l1; cfg_lo2 = l2;
    sof = 1;
    @(negedge clk);
    sof = 0;
    if (scramble) begin
      cfg_mode = 3'b000; cfg_hi1 = 8'h00; cfg_hi2 = 8'h00; cfg_lo1 = 8'h00; cfg_lo2 = 8'h00;
    end
    foreach (bytes[i]) begin
      byte_vld = 1; byte_in = bytes[i];
      @(negedge clk);
    end
    byte_vld = 0; byte_in = 8'h00;
    eof = 1;
    @(negedge clk);
    eof = 0;
    repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done && (dec_vld || out_vld || out_eof)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected output event", {dec_vld, out_vld, out_eof}, 0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        case (e.kind)
          2'd0: begin
            check(dec_vld, t, "decision strobe", dec_vld, 1);
            check(dec_accept == e.acc, t, "accept", dec_accept, e.acc);
            check(hi_code == e.hc, t, "hi_code", hi_code, e.hc);
            check(lo_code == e.lc, t, "lo_code", lo_code, e.lc);
          end
          2'd1: begin
            check(out_vld, t, "data strobe", out_vld, 1);
            check(out_data == e.data, t, "data", out_data, e.data);
          end
          default: check(out_eof, t, "end strobe", out_eof, 1);
        endcase
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) begin
      @(negedge clk);
      // R1
      check(!dec_vld && !out_vld && !out_eof, "R1", "quiet after reset",
            {dec_vld, out_vld, out_eof}, 0);
    end
    // R2 R6 R7 both individual 1, payload forwarded
    send_frame("R2", 3'b011, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h14, 8'h05, 8'hA1, 8'h5B});
    // R6 high individual 2, low group 0xFF
    send_frame("R6", 3'b011, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h20, 8'hFF, 8'h33});
    // R2 high group 0xFC, low individual 2
    send_frame("R2", 3'b011, 8'h14, 8'h20, 8'h05, 8'h09, '{8'hFC, 8'h09, 8'h77});
    // R3 command/response bit differs in stored and received value
    send_frame("R3", 3'b011, 8'h16, 8'h20, 8'h05, 8'h09, '{8'h14, 8'h05, 8'hC3});
    send_frame("R3", 3'b011, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h16, 8'h05, 8'hC4});
    // R7 low byte mismatch, payload dropped
    send_frame("R7", 3'b011, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h14, 8'h41, 8'h11, 8'h22});
    // R4 extension bit clear on low byte
    send_frame("R4", 3'b011, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h14, 8'h04, 8'h11});
    // R5 R11 one-byte mode, second byte is payload
    send_frame("R5", 3'b010, 8'h15, 8'h21, 8'h05, 8'h09, '{8'h15, 8'h05, 8'h66});
    // R4 one-byte mode, extension bit clear
    send_frame("R4", 3'b010, 8'h15, 8'h21, 8'h05, 8'h09, '{8'h14, 8'h05});
    // R8 early end in two-byte mode and in one-byte mode
    send_frame("R8", 3'b011, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h20});
    send_frame("R8", 3'b010, 8'h15, 8'h21, 8'h05, 8'h09, '{});
    // R9 pass-through modes
    send_frame("R9", 3'b000, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h99, 8'h88, 8'h01});
    send_frame("R9", 3'b110, 8'h14, 8'h20, 8'h05, 8'h09, '{8'h00, 8'h42});
    // R10 configuration scrambled right after start of frame
    scramble = 1;
    send_frame("R10", 3'b011, 8'h30, 8'h40, 8'h0B, 8'h0D, '{8'h40, 8'h0B, 8'hEE});
    scramble = 0;
    // R6 priority: both individual values equal
    send_frame("R6", 3'b011, 8'h50, 8'h50, 8'h07, 8'h07, '{8'h50, 8'h07});
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7", "pending expected events", exp_q.size(), 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule